// File: doc/BRIEF.md
# Tiled Surface Address Sequencer

The sequencer walks a rectangular region of a 2D surface and emits, for every element of the region, a pair of byte offsets. One offset points into a plain row-major buffer. The other points into a surface that is split into square tiles, with a bit-swizzled element order inside each tile. A start pulse latches the region origin, the size, both strides, a bytes-per-element shift code, a compressed-block mode flag and a direction flag. Address pairs then leave one per cycle on a valid/ready handshake, and a done pulse closes the region. The data path that moves the pixels is left to the caller.

In normal mode a tile holds 16x16 elements and the in-tile index interleaves the y bits with x bits, each x bit XORed with its paired y bit. In compressed mode the region size is given in pixels and rounded up to whole 4x4 blocks. The origin is then given in block units, and a tile holds 4x4 blocks. The direction flag travels alongside each beat and does not change the addresses.

Top module: `tile_addr_seq`

## Requirements
- R1: After a start with a nonzero region, valid_o rises on the next cycle. Beats run row by row from the origin, left to right within a row, and the first beat has lin_addr_o = 0.
- R2: In normal mode the in-tile index of element (x, y) is, bit 7 down to bit 0: y[3], x[3]^y[3], y[2], x[2]^y[2], y[1], x[1]^y[1], y[0], x[0]^y[0].
- R3: In normal mode tile_addr_o = (y with bits 3:0 cleared) * tile_stride_i + (((x >> 4) * 256 + index) << shift), where x and y are absolute surface coordinates.
- R4: bpp_shift_i values 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 bytes per element. Both addresses scale by that shift.
- R5: lin_addr_o = row * lin_stride_i + (col << shift), where row and col count from the region origin.
- R6: With cmp_mode_i = 1, the width and height become ceil(n/4) blocks. The index is 4 bits wide: y[1], x[1]^y[1], y[0], x[0]^y[0]. The tile offset is (x >> 2) * 16, and the row base is (y with bits 1:0 cleared) * tile_stride_i.
- R7: Origins and sizes need no tile alignment. Partial tiles on any edge, and tile-row crossings, give correct addresses.
- R8: While valid_o is high and ready_i is low, all outputs hold their values. The walk advances only when valid_o and ready_i are both high.
- R9: last_o is high on the final beat of the region and on no other beat.
- R10: done_o is high for exactly one cycle, the cycle after the final beat is accepted. valid_o is low in that cycle.
- R11: A region with zero width or zero height produces no beats. done_o is high on the cycle after the start.
- R12: A start pulse while a region is in progress has no effect on the address stream.
- R13: While rst_ni is low, valid_o and done_o are low.
- R14: store_o carries the store_i value latched at start on every beat of the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches the region setup |
| org_x_i | input | CW | Region origin x (in blocks in compressed mode) |
| org_y_i | input | CW | Region origin y (in blocks in compressed mode) |
| width_i | input | CW | Region width in pixels |
| height_i | input | CW | Region height in pixels |
| tile_stride_i | input | SW | Tiled surface bytes per element row |
| lin_stride_i | input | SW | Linear buffer bytes per row |
| bpp_shift_i | input | 3 | log2 of bytes per element, 0 to 4 |
| cmp_mode_i | input | 1 | 1 selects 4x4 block-compressed mode |
| store_i | input | 1 | Direction: 1 store into tiled, 0 load from it |
| valid_o | output | 1 | Address pair valid |
| ready_i | input | 1 | Consumer accepts the current pair |
| tile_addr_o | output | AW | Byte offset in the tiled surface |
| lin_addr_o | output | AW | Byte offset in the linear buffer |
| last_o | output | 1 | Final beat of the region |
| store_o | output | 1 | Latched direction flag |
| done_o | output | 1 | One-cycle end-of-region pulse |

## Verification
The embedded properties check on every cycle that a stalled beat keeps all of its outputs, and that the first beat of a region starts at linear offset zero. They also check that an accepted final beat is followed by done with valid low, that an empty region gives done straight away, and that a start arriving mid-region leaves the walk position unchanged. The swizzle values, the tile-row and partial-tile crossings, every element size, compressed rounding, and whether the stream is intact after an ignored start can only be shown by the bench. The bench compares each cycle against a model that computes every address bit by bit from absolute coordinates.

// File: rtl/tas_pkg.sv
package tas_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} tas_state_e;

  // each y bit fills an (odd, even) bit pair
  function automatic logic [7:0] dup_bits(logic [3:0] v);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[2*i]   = v[i];
      r[2*i+1] = v[i];
    end
    return r;
  endfunction

  // x bits go to even positions
  function automatic logic [7:0] spread_bits(logic [3:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) r[2*i] = v[i];
    return r;
  endfunction

endpackage

// File: rtl/tas_walk.sv
module tas_walk
  import tas_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] width_i,
  input  logic [CW-1:0] height_i,
  input  logic          cmp_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic          fire_o,
  output logic          eol_o,
  output logic          last_o,
  output logic          done_o,
  output logic          load_o,
  output logic [CW-1:0] col_o
);

  tas_state_e    state_q;
  logic [CW-1:0] col_q, row_q, w_q, h_q;
  logic [CW-1:0] w_eff, h_eff, w_blk, h_blk;
  logic          done_q, zero, idle, last_row;

  // ceil(n/4) without losing the carry at full width
  assign w_blk = (width_i >> 2) + CW'(|width_i[1:0]);
  assign h_blk = (height_i >> 2) + CW'(|height_i[1:0]);
  assign w_eff = cmp_i ? w_blk : width_i;
  assign h_eff = cmp_i ? h_blk : height_i;
  assign zero  = (w_eff == '0) || (h_eff == '0);
  assign idle  = (state_q == ST_IDLE);

  assign load_o   = start_i && idle && !zero;
  assign valid_o  = (state_q == ST_RUN);
  assign fire_o   = valid_o && ready_i;
  assign eol_o    = (col_q == w_q - CW'(1));
  assign last_row = (row_q == h_q - CW'(1));
  assign last_o   = valid_o && eol_o && last_row;
  assign done_o   = done_q;
  assign col_o    = col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      row_q   <= '0;
      w_q     <= '0;
      h_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && idle) begin
        if (zero) begin
          done_q <= 1'b1;
        end else begin
          state_q <= ST_RUN;
          col_q   <= '0;
          row_q   <= '0;
          w_q     <= w_eff;
          h_q     <= h_eff;
        end
      end else if (fire_o) begin
        if (eol_o) begin
          col_q <= '0;
          if (last_row) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            row_q <= row_q + CW'(1);
          end
        end else begin
          col_q <= col_q + CW'(1);
        end
      end
    end
  end

  a_r11_empty_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && idle && zero |=> done_o && !valid_o);

  a_r12_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && valid_o && !ready_i |=> valid_o && $stable(col_q) && $stable(row_q));

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  a_r9_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && last_o |=> done_o && !valid_o);

endmodule

// File: rtl/tas_row_gen.sv
module tas_row_gen
  import tas_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 32,
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [CW-1:0] org_y_i,
  input  logic [SW-1:0] tile_stride_i,
  input  logic [SW-1:0] lin_stride_i,
  input  logic          cmp_i,
  output logic [7:0]    yterm_o,
  output logic [AW-1:0] tbase_o,
  output logic [AW-1:0] lbase_o
);

  logic [CW-1:0] y_q, y_nxt, y_al;
  logic [SW-1:0] tstr_q, lstr_q;
  logic          cmp_q, wrap;
  logic [7:0]    yterm_q;
  logic [AW-1:0] tbase_q, lbase_q, tstep;

  assign y_al  = cmp_i ? (org_y_i & ~CW'(3)) : (org_y_i & ~CW'(15));
  assign y_nxt = y_q + CW'(1);
  assign wrap  = cmp_q ? (y_q[1:0] == 2'b11) : (y_q[3:0] == 4'hf);
  // one tile row = tile height element rows
  assign tstep = cmp_q ? (AW'(tstr_q) << 2) : (AW'(tstr_q) << 4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q     <= '0;
      tstr_q  <= '0;
      lstr_q  <= '0;
      cmp_q   <= 1'b0;
      yterm_q <= '0;
      tbase_q <= '0;
      lbase_q <= '0;
    end else if (load_i) begin
      y_q     <= org_y_i;
      tstr_q  <= tile_stride_i;
      lstr_q  <= lin_stride_i;
      cmp_q   <= cmp_i;
      yterm_q <= dup_bits(cmp_i ? {2'b00, org_y_i[1:0]} : org_y_i[3:0]);
      tbase_q <= AW'(y_al) * AW'(tile_stride_i);
      lbase_q <= '0;
    end else if (adv_i) begin
      y_q     <= y_nxt;
      yterm_q <= dup_bits(cmp_q ? {2'b00, y_nxt[1:0]} : y_nxt[3:0]);
      lbase_q <= lbase_q + AW'(lstr_q);
      if (wrap) tbase_q <= tbase_q + tstep;
    end
  end

  assign yterm_o = yterm_q;
  assign tbase_o = tbase_q;
  assign lbase_o = lbase_q;

  a_r3_base_in_tile: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && !wrap |=> $stable(tbase_q));

  a_r6_narrow_yterm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_q && !load_i |-> yterm_q[7:4] == 4'h0);

endmodule

// File: rtl/tas_swizzle.sv
module tas_swizzle
  import tas_pkg::*;
#(
  parameter int CW     = 16,
  parameter int AW     = 32,
  parameter bit CMP_EN = 1'b1
) (
  input  logic [CW-1:0] x_i,
  input  logic [7:0]    yterm_i,
  input  logic          cmp_i,
  input  logic [2:0]    shift_i,
  input  logic [AW-1:0] tbase_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] elem_n, elem;
  logic [7:0]    idx_n;

  assign idx_n  = yterm_i ^ spread_bits(x_i[3:0]);
  assign elem_n = (AW'(x_i >> 4) << 8) | AW'(idx_n);

  generate
    if (CMP_EN) begin : g_cmp
      logic [7:0]    sp_c;
      logic [3:0]    idx_c;
      logic [AW-1:0] elem_c;
      assign sp_c   = spread_bits({2'b00, x_i[1:0]});
      assign idx_c  = yterm_i[3:0] ^ sp_c[3:0];
      assign elem_c = (AW'(x_i >> 2) << 4) | AW'(idx_c);
      assign elem   = cmp_i ? elem_c : elem_n;
    end else begin : g_plain
      logic unused_cmp;
      assign unused_cmp = cmp_i;
      assign elem = elem_n;
    end
  endgenerate

  assign addr_o = tbase_i + (elem << shift_i);

endmodule

// File: rtl/tile_addr_seq.sv
module tile_addr_seq
  import tas_pkg::*;
#(
  parameter int CW     = 16,
  parameter int SW     = 32,
  parameter int AW     = 32,
  parameter bit CMP_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] org_x_i,
  input  logic [CW-1:0] org_y_i,
  input  logic [CW-1:0] width_i,
  input  logic [CW-1:0] height_i,
  input  logic [SW-1:0] tile_stride_i,
  input  logic [SW-1:0] lin_stride_i,
  input  logic [2:0]    bpp_shift_i,
  input  logic          cmp_mode_i,
  input  logic          store_i,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [AW-1:0] tile_addr_o,
  output logic [AW-1:0] lin_addr_o,
  output logic          last_o,
  output logic          store_o,
  output logic          done_o
);

  logic          fire, eol, load, cmp_in;
  logic [CW-1:0] col, org_x_q, cur_x;
  logic [2:0]    shift_q;
  logic          store_q, cmp_q;
  logic [7:0]    yterm;
  logic [AW-1:0] tbase, lbase;

  assign cmp_in = CMP_EN && cmp_mode_i;

  tas_walk #(.CW(CW)) u_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .width_i  (width_i),
    .height_i (height_i),
    .cmp_i    (cmp_in),
    .ready_i  (ready_i),
    .valid_o  (valid_o),
    .fire_o   (fire),
    .eol_o    (eol),
    .last_o   (last_o),
    .done_o   (done_o),
    .load_o   (load),
    .col_o    (col)
  );

  tas_row_gen #(.CW(CW), .SW(SW), .AW(AW)) u_row (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load),
    .adv_i         (fire && eol),
    .org_y_i       (org_y_i),
    .tile_stride_i (tile_stride_i),
    .lin_stride_i  (lin_stride_i),
    .cmp_i         (cmp_in),
    .yterm_o       (yterm),
    .tbase_o       (tbase),
    .lbase_o       (lbase)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      org_x_q <= '0;
      shift_q <= '0;
      store_q <= 1'b0;
      cmp_q   <= 1'b0;
    end else if (load) begin
      org_x_q <= org_x_i;
      shift_q <= bpp_shift_i;
      store_q <= store_i;
      cmp_q   <= cmp_in;
    end
  end

  assign cur_x = org_x_q + col;

  tas_swizzle #(.CW(CW), .AW(AW), .CMP_EN(CMP_EN)) u_swz (
    .x_i     (cur_x),
    .yterm_i (yterm),
    .cmp_i   (cmp_q),
    .shift_i (shift_q),
    .tbase_i (tbase),
    .addr_o  (tile_addr_o)
  );

  assign lin_addr_o = lbase + (AW'(col) << shift_q);
  assign store_o    = store_q;

  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(tile_addr_o) && $stable(lin_addr_o) && $stable(last_o));

  a_r5_first_lin_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> lin_addr_o == '0);

  a_r14_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !fire |=> $stable(store_o));

  a_r1_start_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> valid_o);

endmodule

// File: tb/sim_tile_addr_seq.sv
module sim_tile_addr_seq;

  localparam int CW = 16;
  localparam int SW = 32;
  localparam int AW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] org_x = '0, org_y = '0, wid = '0, hgt = '0;
  logic [SW-1:0] tstr = '0, lstr = '0;
  logic [2:0]    shift = '0;
  logic          cmp = 1'b0, store = 1'b0, rdy = 1'b0;
  logic          valid, last, store_out, done;
  logic [AW-1:0] taddr, laddr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_addr_seq #(.CW(CW), .SW(SW), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .org_x_i(org_x), .org_y_i(org_y), .width_i(wid), .height_i(hgt),
    .tile_stride_i(tstr), .lin_stride_i(lstr), .bpp_shift_i(shift),
    .cmp_mode_i(cmp), .store_i(store), .valid_o(valid), .ready_i(rdy),
    .tile_addr_o(taddr), .lin_addr_o(laddr), .last_o(last),
    .store_o(store_out), .done_o(done)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // model: every address bit placed from absolute coordinates
  function automatic longint m_tiled(int x, int y, bit c, longint st, int sh);
    int n = c ? 2 : 4;
    longint idx = 0;
    longint base, elem;
    for (int i = 0; i < n; i++) begin
      idx |= longint'((y >> i) & 1) << (2*i + 1);
      idx |= longint'(((x >> i) ^ (y >> i)) & 1) << (2*i);
    end
    base = (longint'(y) & ~longint'((1 << n) - 1)) * st;
    elem = (longint'(x >> n) << (2*n)) + idx;
    return (base + (elem << sh)) & 64'hFFFF_FFFF;
  endfunction

  longint q_t[$];
  longint q_l[$];

  // rmode: 0 always ready, 1 random, 2 alternating; glitch_k<0 disables
  task automatic run_region(int x, int y, int w, int h, longint ts, longint ls,
                            int sh, bit c, bit st, int rmode, int glitch_k, string tag);
    int we, he, iter;
    bit pend_done;
    q_t.delete();
    q_l.delete();
    we = c ? (w + 3) / 4 : w;
    he = c ? (h + 3) / 4 : h;
    for (int r = 0; r < he; r++)
      for (int cc = 0; cc < we; cc++) begin
        q_t.push_back(m_tiled(x + cc, y + r, c, ts, sh));
        q_l.push_back((longint'(r) * ls + (longint'(cc) << sh)) & 64'hFFFF_FFFF);
      end
    @(negedge clk);
    org_x = CW'(x); org_y = CW'(y); wid = CW'(w); hgt = CW'(h);
    tstr = SW'(ts); lstr = SW'(ls); shift = 3'(sh); cmp = c; store = st;
    start = 1'b1; rdy = 1'b0;
    @(negedge clk);
    start = 1'b0;
    pend_done = (q_t.size() == 0);
    iter = 0;
    forever begin
      if (pend_done) begin
        check(done == 1'b1, {tag, " R10/R11 done"}, done, 1);
        check(valid == 1'b0, {tag, " R10 valid low at done"}, valid, 0);
        break;
      end
      check(done == 1'b0, {tag, " R10 no early done"}, done, 0);
      check(valid == 1'b1, {tag, " R1 valid during region"}, valid, 1);
      if (valid) begin
        check(taddr == AW'(q_t[0]), {tag, " R3 tile addr"}, taddr, q_t[0]);
        check(laddr == AW'(q_l[0]), {tag, " R5 linear addr"}, laddr, q_l[0]);
        check(last == (q_t.size() == 1), {tag, " R9 last"}, last, q_t.size() == 1);
        check(store_out == st, {tag, " R14 direction"}, store_out, st);
      end
      if (iter == glitch_k) begin
        start = 1'b1; org_x = 16'h0123; org_y = 16'h0077; wid = 16'd3; hgt = 16'd2;
        tstr = 32'h999; lstr = 32'h55; shift = 3'd1; cmp = ~c; store = ~st;
      end else begin
        start = 1'b0;
      end
      case (rmode)
        0: rdy = 1'b1;
        1: rdy = ($urandom_range(0, 2) != 0);
        default: rdy = iter[0];
      endcase
      if (valid && rdy && q_t.size() > 0) begin
        void'(q_t.pop_front());
        void'(q_l.pop_front());
        if (q_t.size() == 0) pend_done = 1'b1;
      end
      iter++;
      if (iter > 20000) begin
        check(1'b0, {tag, " R1 region hung"}, iter, 0);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    rdy = 1'b0;
    @(negedge clk);
    check(done == 1'b0, {tag, " R10 single-cycle done"}, done, 0);
    check(valid == 1'b0, {tag, " R11/R10 idle after"}, valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R13 reset valid", valid, 0);
    check(done == 1'b0, "R13 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // aligned tile, 4 bytes
    run_region(0, 0, 16, 16, 256, 64, 2, 0, 0, 0, -1, "R1 R2 aligned");
    // unaligned, crosses tile column and row, 1 byte, random stalls
    run_region(5, 3, 23, 20, 96, 40, 0, 0, 1, 1, -1, "R7 R8 unaligned");
    // 16-byte elements, alternating ready
    run_region(17, 30, 9, 5, 1024, 200, 4, 0, 1, 2, -1, "R4 shift4");
    run_region(14, 13, 6, 7, 128, 30, 1, 0, 0, 1, -1, "R4 shift1");
    run_region(31, 15, 3, 3, 512, 48, 3, 0, 0, 0, -1, "R4 shift3");
    // compressed mode, rounding to blocks
    run_region(3, 1, 10, 7, 64, 48, 3, 1, 0, 1, -1, "R6 blocks");
    run_region(6, 7, 1, 1, 32, 16, 4, 1, 1, 0, -1, "R6 single block");
    run_region(1, 2, 16, 13, 40, 100, 2, 1, 0, 2, -1, "R6 R7 block edges");
    // empty regions
    run_region(4, 4, 0, 5, 64, 64, 2, 0, 0, 0, -1, "R11 zero width");
    run_region(4, 4, 5, 0, 64, 64, 2, 0, 0, 0, -1, "R11 zero height");
    run_region(4, 4, 0, 8, 64, 64, 2, 1, 0, 0, -1, "R11 cmp zero");
    // start during a region
    run_region(9, 6, 12, 4, 200, 60, 2, 0, 1, 1, 3, "R12 start mid-run");
    run_region(2, 2, 20, 3, 300, 80, 1, 0, 0, 0, 5, "R12 start full-rate");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule